// File: doc/BRIEF.md
# Bit-band alias bridge

This bridge sits on a simple request/ready bus between one master and one memory-mapped target. It adds an alias window in which every 32-bit aligned address stands for a single bit of the real peripheral region. A write to an alias address sets or clears that one bit. The bridge does this as a read-modify-write on the target, and it holds a lock output across both halves so that no other master can reach the target in between. A read from an alias address returns the addressed bit in bit 0 of the read data.

The transfer size the master uses on the alias access is also the size of the target cycles. A byte alias access therefore touches one byte of the target word, and a halfword access touches one halfword. Software can use this to pick an access width that the target accepts. Addresses outside the window pass straight through to the target in the same cycle.

Top module: `bitband_bridge`

## Requirements
- R1: An access outside the alias window reaches the target in the same cycle with address, size, write flag and write data unchanged. Target ready and read data return directly to the master, and the lock stays low.
- R2: An address is in the alias window when ALIAS_BASE <= addr < ALIAS_BASE + 2^(REAL_AW+5). The defaults give 0x42000000 to 0x43FFFFFF, and the addresses on either side of those limits pass through.
- R3: For an alias address, let o = addr - ALIAS_BASE. The real byte is B = o[REAL_AW+4:5], the bit within that byte is o[4:2], and o[1:0] is ignored. The target word is REAL_BASE + (B with bits [1:0] cleared), and the bit index in that word is n = 8*(B mod 4) + o[4:2].
- R4: Size codes are 0 for byte, 1 for halfword and 2 for word, and the target cycles use the master's size code. The unit address is the word address plus n/8 for a byte, plus 2*(n/16) for a halfword, and plus 0 for a word. The bit position within the unit is n modulo the unit width. Unit data sits right-aligned in bits [w-1:0] of the read and write data buses. A byte alias write to a target that accepts only word writes therefore leaves that target unchanged, while a word alias write changes it.
- R5: An alias read makes exactly one target read with the lock high. The master gets the selected unit bit in bit 0, and bits [31:1] are zero.
- R6: An alias write makes one target read and then one target write, both to the same address and size. The lock stays high continuously through both. Bit 0 of the master write data sets the bit (1) or clears it (0), and write data bits [31:1] are ignored. All other bits of the unit are written back unchanged, and bits above the unit width are written as zero.
- R7: In the cycle an alias request is accepted, no target request is issued and the master is not ready. Master ready rises in the cycle after the last target handshake. With a zero-wait target, an alias read is ready in its third cycle and an alias write in its fourth.
- R8: The target may hold ready low for any number of cycles. The bridge keeps its target request, address and lock steady until ready arrives.
- R9: While reset is active and no request is pending, target request, lock and master ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 1 | Master request, held until m_ready |
| m_we | input | 1 | Master write flag |
| m_size | input | 2 | Master transfer size (0 byte, 1 halfword, 2 word) |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data, right-aligned |
| m_ready | output | 1 | Transfer complete to master |
| m_rdata | output | 32 | Read data to master, valid with m_ready |
| t_req | output | 1 | Target request |
| t_we | output | 1 | Target write flag |
| t_size | output | 2 | Target transfer size |
| t_addr | output | 32 | Target byte address |
| t_wdata | output | 32 | Target write data, right-aligned |
| t_lock | output | 1 | Held high across an alias read or read-modify-write |
| t_ready | input | 1 | Target transfer complete |
| t_rdata | input | 32 | Target read data, right-aligned |

## Verification
The hardest case to reach from the ports is a read-modify-write stretched by target wait states. The lock must stay high through every stalled cycle, and the write must land on the same unit as the read. The bench gets there with a target model whose ready is delayed by a programmable number of cycles. It records every target handshake with its lock, size and address, and it counts any cycle of an alias operation in which a target request appears without the lock. A second part of the target accepts only word writes, so that byte alias writes are shown to be dropped while word alias writes to bits 8 to 15 succeed.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int POS_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } rmw_state_e;

  // Valid bits of a right-aligned unit of the given size.
  function automatic logic [DATA_W-1:0] unit_mask(input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_BYTE: return DATA_W'(32'h0000_00FF);
      SZ_HALF: return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  // Byte offset of the unit holding word bit n.
  function automatic logic [ADDR_W-1:0] unit_offset(input logic [POS_W-1:0] n,
                                                     input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_BYTE: return ADDR_W'(n[4:3]);
      SZ_HALF: return ADDR_W'({n[4], 1'b0});
      default: return '0;
    endcase
  endfunction

  // Position of word bit n inside its unit.
  function automatic logic [POS_W-1:0] unit_pos(input logic [POS_W-1:0] n,
                                                 input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_BYTE: return POS_W'(n[2:0]);
      SZ_HALF: return POS_W'(n[3:0]);
      default: return n;
    endcase
  endfunction

  // Old unit value with one bit forced to val.
  function automatic logic [DATA_W-1:0] apply_bit(input logic [DATA_W-1:0] old_unit,
                                                   input logic [POS_W-1:0] pos,
                                                   input logic val);
    logic [DATA_W-1:0] r;
    r = old_unit;
    r[pos] = val;
    return r;
  endfunction
endpackage

// File: rtl/bitband_decode.sv
module bitband_decode
  import bitband_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4200_0000,
  parameter logic [ADDR_W-1:0] REAL_BASE  = 32'h4000_0000,
  parameter int                REAL_AW    = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [ADDR_W-1:0] unit_addr,
  output logic [POS_W-1:0]  pos
);
  localparam int OFF_W = REAL_AW + 5;

  logic [ADDR_W-1:0]  off;
  logic [REAL_AW-1:0] byte_off;
  logic [POS_W-1:0]   bitnum;
  logic [ADDR_W-1:0]  word_addr;

  assign off       = addr - ALIAS_BASE;
  assign hit       = (addr >= ALIAS_BASE) && ((off >> OFF_W) == '0);
  assign byte_off  = off[OFF_W-1:5];
  assign bitnum    = {byte_off[1:0], off[4:2]};
  assign word_addr = REAL_BASE + ADDR_W'({byte_off[REAL_AW-1:2], 2'b00});
  assign unit_addr = word_addr + unit_offset(bitnum, size);
  assign pos       = unit_pos(bitnum, size);
endmodule

// File: rtl/bitband_rmw.sv
module bitband_rmw
  import bitband_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic              set_val,
  input  logic [1:0]        size,
  input  logic [POS_W-1:0]  pos,
  input  logic              t_ready,
  input  logic [DATA_W-1:0] t_rdata,
  output logic              busy,
  output logic              rd_phase,
  output logic              wr_phase,
  output logic              resp_phase,
  output logic [DATA_W-1:0] new_unit,
  output logic              read_bit
);
  rmw_state_e        state, state_nx;
  logic [DATA_W-1:0] old_unit;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start)   state_nx = ST_READ;
      ST_READ:  if (t_ready) state_nx = is_write ? ST_WRITE : ST_RESP;
      ST_WRITE: if (t_ready) state_nx = ST_RESP;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      old_unit <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_READ && t_ready) old_unit <= t_rdata & unit_mask(size);
    end
  end

  assign busy       = (state != ST_IDLE);
  assign rd_phase   = (state == ST_READ);
  assign wr_phase   = (state == ST_WRITE);
  assign resp_phase = (state == ST_RESP);
  assign new_unit   = apply_bit(old_unit, pos, set_val);
  assign read_bit   = old_unit[pos];

  // R6: a write request always moves from read phase to write phase
  a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && t_ready && is_write) |=> wr_phase);
  // R6: the written unit differs from the one read in at most one bit
  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |-> ($countones(new_unit ^ old_unit) <= 1));
  // R8: a stalled phase is held
  a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && !t_ready) |=> rd_phase);
  a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && !t_ready) |=> wr_phase);
  // R7: the response lasts one cycle
  a_r7_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    resp_phase |=> !resp_phase);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bitband_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4200_0000,
  parameter logic [ADDR_W-1:0] REAL_BASE  = 32'h4000_0000,
  parameter int                REAL_AW    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [1:0]        m_size,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_ready,
  output logic [DATA_W-1:0] m_rdata,
  output logic              t_req,
  output logic              t_we,
  output logic [1:0]        t_size,
  output logic [ADDR_W-1:0] t_addr,
  output logic [DATA_W-1:0] t_wdata,
  output logic              t_lock,
  input  logic              t_ready,
  input  logic [DATA_W-1:0] t_rdata
);
  localparam logic [ADDR_W-1:0] REAL_SPAN = ADDR_W'(1) << REAL_AW;

  logic              hit;
  logic [ADDR_W-1:0] unit_addr;
  logic [POS_W-1:0]  pos;
  logic              busy, rd_phase, wr_phase, resp_phase, read_bit;
  logic [DATA_W-1:0] new_unit;
  logic              alias_start;
  logic              pass_active;

  bitband_decode #(
    .ALIAS_BASE(ALIAS_BASE),
    .REAL_BASE (REAL_BASE),
    .REAL_AW   (REAL_AW)
  ) u_decode (
    .addr     (m_addr),
    .size     (m_size),
    .hit      (hit),
    .unit_addr(unit_addr),
    .pos      (pos)
  );

  assign alias_start = m_req && hit && !busy;
  assign pass_active = m_req && !hit && !busy;

  bitband_rmw u_rmw (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (alias_start),
    .is_write  (m_we),
    .set_val   (m_wdata[0]),
    .size      (m_size),
    .pos       (pos),
    .t_ready   (t_ready),
    .t_rdata   (t_rdata),
    .busy      (busy),
    .rd_phase  (rd_phase),
    .wr_phase  (wr_phase),
    .resp_phase(resp_phase),
    .new_unit  (new_unit),
    .read_bit  (read_bit)
  );

  always_comb begin
    t_req   = pass_active;
    t_we    = m_we;
    t_size  = m_size;
    t_addr  = m_addr;
    t_wdata = m_wdata;
    t_lock  = 1'b0;
    m_ready = pass_active && t_ready;
    m_rdata = t_rdata;
    if (busy) begin
      t_req   = rd_phase || wr_phase;
      t_we    = wr_phase;
      t_addr  = unit_addr;
      t_wdata = wr_phase ? new_unit : '0;
      t_lock  = rd_phase || wr_phase;
      m_ready = resp_phase;
      m_rdata = (resp_phase && !m_we) ? DATA_W'(read_bit) : '0;
    end
  end

  // R1: outside the window the target sees the master's transfer, unlocked
  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    pass_active |-> (t_req && !t_lock && t_addr == m_addr && t_size == m_size
                     && t_we == m_we && m_ready == t_ready));
  // R3: alias traffic stays inside the real region
  a_r3_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    (t_req && t_lock) |-> ((t_addr - REAL_BASE) < REAL_SPAN));
  // R5: alias read data carries only bit 0
  a_r5_read_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_phase && !m_we) |-> ((m_rdata >> 1) == '0));
  // R6: lock, address and size carry over from read to write
  a_r6_locked_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (t_lock && t_req && !t_we && t_ready && m_we) |=>
      (t_lock && t_req && t_we && t_addr == $past(t_addr) && t_size == $past(t_size)));
  // R7: no target request and no ready in the accepting cycle
  a_r7_accept_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    alias_start |-> (!t_req && !m_ready));
endmodule

// File: tb/bitband_bridge_test.sv
module bitband_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [1:0]  m_size = 2'd2;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic        m_ready;
  logic [31:0] m_rdata;
  logic        t_req, t_we, t_lock;
  logic [1:0]  t_size;
  logic [31:0] t_addr, t_wdata;
  logic        t_ready;
  logic [31:0] t_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5ns clk = ~clk;

  bitband_bridge uut (.*);

  // ---- target model: 64 words at 0x40000000, upper half word-write only ----
  logic [31:0] mem [64];
  int          tgt_wait = 0;
  int          wait_cnt = 0;
  logic        in_mem;
  logic [5:0]  idx;

  assign in_mem  = (t_addr[31:8] == 24'h400000);
  assign idx     = t_addr[7:2];
  assign t_ready = t_req && (wait_cnt >= tgt_wait);

  always_comb begin
    logic [31:0] w;
    w = mem[idx];
    if (!in_mem)            t_rdata = t_addr ^ 32'hA5A5_A5A5;
    else if (t_size == 2'd0) t_rdata = (w >> (8 * t_addr[1:0])) & 32'hFF;
    else if (t_size == 2'd1) t_rdata = (w >> (16 * t_addr[1])) & 32'hFFFF;
    else                     t_rdata = w;
  end

  // handshake log
  int          log_n = 0;
  logic        log_we [8];
  logic        log_lock [8];
  logic [1:0]  log_size [8];
  logic [31:0] log_addr [8];
  logic [31:0] log_wdata [8];
  bit          alias_op = 0;
  int          lock_gap = 0;

  always @(posedge clk) begin
    if (t_req && !t_ready) wait_cnt <= wait_cnt + 1;
    else                   wait_cnt <= 0;
    if (alias_op && t_req && !t_lock) lock_gap <= lock_gap + 1;
    if (t_req && t_ready) begin
      if (log_n < 8) begin
        log_we[log_n]    <= t_we;
        log_lock[log_n]  <= t_lock;
        log_size[log_n]  <= t_size;
        log_addr[log_n]  <= t_addr;
        log_wdata[log_n] <= t_wdata;
      end
      log_n <= log_n + 1;
      if (t_we && in_mem && !(idx >= 6'd32 && t_size != 2'd2)) begin
        case (t_size)
          2'd0: mem[idx][8*t_addr[1:0] +: 8] <= t_wdata[7:0];
          2'd1: mem[idx][16*t_addr[1] +: 16] <= t_wdata[15:0];
          default: mem[idx] <= t_wdata;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    alias_op = (addr >= 32'h4200_0000) && (addr < 32'h4400_0000);
    m_req = 1'b1; m_we = we; m_addr = addr; m_size = sz; m_wdata = wd;
    waits = 0;
    #1ns;
    while (!m_ready && waits < 100) begin
      @(negedge clk);
      waits++;
      #1ns;
    end
    rd = m_rdata;
    @(posedge clk);
    #1ns;
    m_req = 1'b0;
    alias_op = 0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h4000_0010, 2'd2, 32'h1234_5678, 1'b0, 32'h0,          4'd1}, // R1 seed word
    '{1'b0, 32'h4000_0010, 2'd2, 32'h0,         1'b1, 32'h1234_5678, 4'd1}, // R1
    '{1'b0, 32'h4200_0228, 2'd2, 32'h0,         1'b1, 32'h1,          4'd3}, // R3 byte 0x11 bit 2
    '{1'b0, 32'h4200_0200, 2'd2, 32'h0,         1'b1, 32'h0,          4'd5}, // R5
    '{1'b1, 32'h4200_0200, 2'd2, 32'h1,         1'b0, 32'h0,          4'd6}, // R6 set bit 0
    '{1'b0, 32'h4000_0010, 2'd2, 32'h0,         1'b1, 32'h1234_5679, 4'd6}, // R6
    '{1'b1, 32'h4200_0270, 2'd0, 32'hFFFF_FFFE, 1'b0, 32'h0,          4'd4}, // R4 byte clear bit 28
    '{1'b0, 32'h4000_0010, 2'd2, 32'h0,         1'b1, 32'h0234_5679, 4'd4}, // R4
    '{1'b1, 32'h4200_024C, 2'd1, 32'h3,         1'b0, 32'h0,          4'd4}, // R4 half set bit 19
    '{1'b0, 32'h4000_0010, 2'd2, 32'h0,         1'b1, 32'h023C_5679, 4'd4}, // R4
    '{1'b0, 32'h4200_024C, 2'd1, 32'h0,         1'b1, 32'h1,          4'd4}, // R4
    '{1'b0, 32'h4200_0228, 2'd0, 32'h0,         1'b1, 32'h1,          4'd4}, // R4
    '{1'b1, 32'h4000_00A0, 2'd2, 32'h0000_F00F, 1'b0, 32'h0,          4'd1}, // R1 word-only target
    '{1'b1, 32'h4200_1420, 2'd2, 32'h1,         1'b0, 32'h0,          4'd4}, // R4 word write bit 8
    '{1'b0, 32'h4000_00A0, 2'd2, 32'h0,         1'b1, 32'h0000_F10F, 4'd4}, // R4
    '{1'b1, 32'h4200_1424, 2'd0, 32'h1,         1'b0, 32'h0,          4'd4}, // R4 byte write dropped
    '{1'b0, 32'h4000_00A0, 2'd2, 32'h0,         1'b1, 32'h0000_F10F, 4'd4}, // R4
    '{1'b0, 32'h4200_1424, 2'd2, 32'h0,         1'b1, 32'h0,          4'd5}, // R5
    '{1'b0, 32'h41FF_FFFC, 2'd2, 32'h0,         1'b1, 32'hE45A_5A59, 4'd2}, // R2 below window
    '{1'b0, 32'h4400_0000, 2'd2, 32'h0,         1'b1, 32'hE1A5_A5A5, 4'd2}, // R2 above window
    '{1'b0, 32'h43FF_FFFC, 2'd2, 32'h0,         1'b1, 32'h1,          4'd2}, // R2 last alias word
    '{1'b0, 32'h4200_0000, 2'd2, 32'h0,         1'b1, 32'h0,          4'd2}, // R2 first alias word
    '{1'b0, 32'h4200_022B, 2'd2, 32'h0,         1'b1, 32'h1,          4'd3}, // R3 low bits ignored
    '{1'b0, 32'h4000_0012, 2'd1, 32'h0,         1'b1, 32'h0000_023C, 4'd1}  // R1 halfword
  };

  initial begin
    logic [31:0] rd;
    int          w;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 t_req", {31'b0, t_req}, 32'h0);
    check("R9 t_lock", {31'b0, t_lock}, 32'h0);
    check("R9 m_ready", {31'b0, m_ready}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].we, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd, w);
      if (VECS[i].chk) check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R5/R7: alias read makes one locked read, ready in third cycle
    log_n = 0;
    access(1'b0, 32'h4200_0200, 2'd2, 32'h0, rd, w);
    check("R5 read data", rd, 32'h1);
    check("R7 read latency", w, 2);
    check("R5 handshake count", log_n, 1);
    check("R5 read is locked read", {30'b0, log_we[0], log_lock[0]}, 32'h1);
    check("R5 read address", log_addr[0], 32'h4000_0010);

    // R6/R7: halfword alias write, bit 1 of word 0x40000010
    log_n = 0;
    access(1'b1, 32'h4200_0204, 2'd1, 32'hFFFF_FFF1, rd, w);
    check("R7 write latency", w, 3);
    check("R6 handshake count", log_n, 2);
    check("R6 read then write", {30'b0, log_we[0], log_we[1]}, 32'h1);
    check("R6 lock on both", {30'b0, log_lock[0], log_lock[1]}, 32'h3);
    check("R6 same address", log_addr[1], log_addr[0]);
    check("R6 write address", log_addr[1], 32'h4000_0010);
    check("R4 size forwarded", {28'b0, log_size[0], log_size[1]}, 32'h5);
    check("R6 write data", log_wdata[1], 32'h0000_567B);

    // R1: pass-through is immediate and unlocked
    log_n = 0;
    access(1'b0, 32'h4000_0010, 2'd2, 32'h0, rd, w);
    check("R1 latency", w, 0);
    check("R1 lock low", {31'b0, log_lock[0]}, 32'h0);
    check("R6 other bits kept", rd, 32'h023C_567B);

    // R8: wait states during read-modify-write
    tgt_wait = 2;
    lock_gap = 0;
    access(1'b1, 32'h4200_0204, 2'd2, 32'h0, rd, w);
    check("R8 stretched latency", w, 7);
    check("R8 lock never dropped", lock_gap, 0);
    tgt_wait = 0;
    access(1'b0, 32'h4000_0010, 2'd2, 32'h0, rd, w);
    check("R8 result after stall", rd, 32'h023C_5679);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule